// File: doc/BRIEF.md
# Four-Bank Interleaved Tightly-Coupled Data Memory Arbiter

This block sits in front of a data tightly-coupled memory made of four independent 32-bit banks. Consecutive 32-bit words land in consecutive banks, so the memory can move 128 bits in one cycle. Two requesters share it. The first is a core load/store port that moves either one word or one aligned doubleword. The second is a 32-bit DMA port.

Each cycle, the block works out which banks the core touches. It steers every bank to its owner and applies byte enables one bank at a time. Read data comes back one cycle after the grant. A doubleword read is reassembled in address order. The DMA port runs in parallel on any bank the core leaves free. When the DMA hits a bank the core is using, the core wins and the DMA is held off through its ready signal.

Top module: `tcm_bank_arbiter`

## Requirements
- R1: Byte address bits [3:2] pick the bank, and the bits above bit 3 pick the row inside that bank. A given word address therefore names the same storage from either port, so data written through one port is read back unchanged through the other.
- R2: A narrow core access (`core_wide`=0) uses only the bank named by `core_addr[3:2]`. It writes from `core_wdata[31:0]` under `core_be[3:0]`. A read returns the word in `core_rdata[31:0]` with `core_rdata[63:32]` zero.
- R3: A wide core access (`core_wide`=1) uses banks {0,1} when `core_addr[3]`=0 and banks {2,3} when it is 1; `core_addr[2:0]` is ignored. The lower-addressed word (even bank) takes `core_wdata[31:0]` and `core_be[3:0]`. The upper word (odd bank) takes `core_wdata[63:32]` and `core_be[7:4]`. A read returns the two words in the same order.
- R4: `core_ready` is 1 in every cycle.
- R5: `dma_ready` is 0 exactly when `core_valid` is 1 and the DMA bank (`dma_addr[3:2]`) is one of the banks the core access uses; otherwise it is 1.
- R6: A DMA request on a bank the core is not using is accepted in the same cycle as the core access. A stalled DMA request keeps `dma_valid` high with stable address, data and direction until it is accepted. It changes no memory while stalled and completes once the conflict clears.
- R7: During a write, only the bytes whose enable bit is 1 change; all other bytes keep their value.
- R8: An accepted read raises that port's read-valid flag, and delivers its data, exactly one cycle later. Writes never raise a read-valid flag.
- R9: During reset and afterwards, neither read-valid flag rises until a read has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_valid | input | 1 | Core request present |
| core_ready | output | 1 | Core request accepted (always 1) |
| core_write | input | 1 | 1 = write, 0 = read |
| core_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit or smaller |
| core_addr | input | ADDR_W | Core byte address |
| core_be | input | 8 | Core byte enables |
| core_wdata | input | 64 | Core write data |
| core_rvalid | output | 1 | Core read data valid |
| core_rdata | output | 64 | Core read data |
| dma_valid | input | 1 | DMA request present |
| dma_ready | output | 1 | DMA request accepted this cycle |
| dma_write | input | 1 | 1 = write, 0 = read |
| dma_addr | input | ADDR_W | DMA byte address |
| dma_be | input | 4 | DMA byte enables |
| dma_wdata | input | 32 | DMA write data |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | 32 | DMA read data |

## Verification
The bench builds the block with `DEPTH_WORDS`=64. That gives 16 rows per bank and an 8-bit address. At this size, random addresses hit the same word and the same bank often, which drives frequent core/DMA collisions. It also lets the bench fill every word before reading, so its model of the memory is fully defined. A behavioural model keyed by word address follows every cycle. Directed cases cover parallel access, stalls held across cycles, the ignored low address bits of wide accesses, and partial byte enables.

// File: rtl/tcm_arb_pkg.sv
// Shared constants and types for the banked tightly-coupled memory arbiter.
// Assumes four banks of 32-bit words, interleaved on byte address bits [3:2].
package tcm_arb_pkg;
    localparam int NUM_BANKS  = 4;
    localparam int WORD_W     = 32;
    localparam int LANE_BYTES = WORD_W / 8;
    localparam int BSEL_W     = $clog2(NUM_BANKS);

    typedef logic [NUM_BANKS-1:0]             bank_mask_t;
    typedef logic [NUM_BANKS-1:0][WORD_W-1:0] bank_data_t;
endpackage

// File: rtl/tcm_bank_sel.sv
// Turns a bank select field and an access width into a one-hot (narrow)
// or two-hot (wide) mask of the banks the access occupies.
// Assumes a wide access covers an aligned bank pair picked by sel[1].
module tcm_bank_sel
    import tcm_arb_pkg::*;
(
    input  logic [BSEL_W-1:0] sel,
    input  logic              wide,
    output bank_mask_t        mask
);
    // Build the occupancy mask for one access
    always_comb begin
        mask = '0;
        if (wide) begin
            mask[{sel[1], 1'b0}] = 1'b1;
            mask[{sel[1], 1'b1}] = 1'b1;
        end else begin
            mask[sel] = 1'b1;
        end
    end
endmodule

// File: rtl/tcm_sram_bank.sv
// Behavioural single-port 32-bit bank with per-byte write enables and a
// registered read port (data valid the cycle after a read).
// Assumes at most one requester drives it in a cycle; contents are not reset.
module tcm_sram_bank #(
    parameter int IDX_W  = 8,
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                en,
    input  logic                we,
    input  logic [IDX_W-1:0]    idx,
    input  logic [WORD_W/8-1:0] be,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata
);
    localparam int DEPTH = 2 ** IDX_W;
    localparam int NBYTE = WORD_W / 8;

    logic [WORD_W-1:0] mem [DEPTH];

    // Byte-masked write and registered read
    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int l = 0; l < NBYTE; l++) begin
                if (be[l]) mem[idx][8*l +: 8] <= wdata[8*l +: 8];
            end
        end else if (en) begin
            rdata <= mem[idx];
        end
    end
endmodule

// File: rtl/tcm_rd_return.sv
// Tracks accepted reads for one cycle and routes the bank outputs back to
// their requesters. A wide core read is rebuilt lower bank first.
// Assumes the banks present read data exactly one cycle after the access.
module tcm_rd_return
    import tcm_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_fire,
    input  logic                core_wide,
    input  logic [BSEL_W-1:0]   core_bank,
    input  logic                dma_fire,
    input  logic [BSEL_W-1:0]   dma_bank,
    input  bank_data_t          bank_rdata,
    output logic                core_rvalid,
    output logic [2*WORD_W-1:0] core_rdata,
    output logic                dma_rvalid,
    output logic [WORD_W-1:0]   dma_rdata
);
    logic              wide_q;
    logic [BSEL_W-1:0] cbank_q;
    logic [BSEL_W-1:0] dbank_q;
    logic [BSEL_W-1:0] lo_bank;

    // Remember which reads were accepted and where they went
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_rvalid <= 1'b0;
            dma_rvalid  <= 1'b0;
            wide_q      <= 1'b0;
            cbank_q     <= '0;
            dbank_q     <= '0;
        end else begin
            core_rvalid <= core_fire;
            dma_rvalid  <= dma_fire;
            wide_q      <= core_wide;
            cbank_q     <= core_bank;
            dbank_q     <= dma_bank;
        end
    end

    // Select and reassemble the returned words
    always_comb begin
        lo_bank = wide_q ? {cbank_q[1], 1'b0} : cbank_q;
        if (wide_q)
            core_rdata = {bank_rdata[{lo_bank[1], 1'b1}], bank_rdata[lo_bank]};
        else
            core_rdata = {{WORD_W{1'b0}}, bank_rdata[lo_bank]};
        dma_rdata = bank_rdata[dbank_q];
    end
endmodule

// File: rtl/tcm_bank_arbiter.sv
// Arbiter for a four-bank word-interleaved data memory shared by a core
// port (32 or 64 bits) and a 32-bit DMA port. The core always wins a bank;
// the DMA is stalled only on the banks the core occupies.
// Assumes DEPTH_WORDS is a power of two and a multiple of the bank count.
module tcm_bank_arbiter
    import tcm_arb_pkg::*;
#(
    parameter int DEPTH_WORDS = 1024,
    parameter int ADDR_W      = $clog2(DEPTH_WORDS) + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_valid,
    output logic                core_ready,
    input  logic                core_write,
    input  logic                core_wide,
    input  logic [ADDR_W-1:0]   core_addr,
    input  logic [7:0]          core_be,
    input  logic [63:0]         core_wdata,
    output logic                core_rvalid,
    output logic [63:0]         core_rdata,
    input  logic                dma_valid,
    output logic                dma_ready,
    input  logic                dma_write,
    input  logic [ADDR_W-1:0]   dma_addr,
    input  logic [3:0]          dma_be,
    input  logic [31:0]         dma_wdata,
    output logic                dma_rvalid,
    output logic [31:0]         dma_rdata
);
    localparam int BANK_DEPTH = DEPTH_WORDS / NUM_BANKS;
    localparam int IDX_W      = $clog2(BANK_DEPTH);
    localparam int IDX_LSB    = 2 + BSEL_W;

    bank_mask_t        core_mask;
    bank_mask_t        dma_mask;
    bank_data_t        bank_rdata;
    logic              dma_fire;
    logic [IDX_W-1:0]  core_idx;
    logic [IDX_W-1:0]  dma_idx;
    logic              unused_addr_bits;

    assign core_idx         = core_addr[IDX_LSB +: IDX_W];
    assign dma_idx          = dma_addr[IDX_LSB +: IDX_W];
    assign unused_addr_bits = ^{core_addr[1:0], dma_addr[1:0]};

    tcm_bank_sel u_core_sel (
        .sel  (core_addr[3:2]),
        .wide (core_wide),
        .mask (core_mask)
    );

    tcm_bank_sel u_dma_sel (
        .sel  (dma_addr[3:2]),
        .wide (1'b0),
        .mask (dma_mask)
    );

    // Core never waits; DMA waits when its bank is under a core access
    always_comb begin
        core_ready = 1'b1;
        dma_ready  = !(core_valid && core_mask[dma_addr[3:2]]);
        dma_fire   = dma_valid && dma_ready;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LANE = b % 2;
        logic              core_hit;
        logic              dma_hit;
        logic              en;
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [3:0]        be;
        logic [31:0]       wdata;

        // Steer this bank to the core if it claims it, else to the DMA
        always_comb begin
            core_hit = core_valid && core_mask[b];
            dma_hit  = dma_fire && dma_mask[b];
            en       = core_hit || dma_hit;
            if (core_hit) begin
                we    = core_write;
                idx   = core_idx;
                be    = core_wide ? core_be[4*LANE +: 4] : core_be[3:0];
                wdata = core_wide ? core_wdata[32*LANE +: 32] : core_wdata[31:0];
            end else begin
                we    = dma_write;
                idx   = dma_idx;
                be    = dma_be;
                wdata = dma_wdata;
            end
        end

        tcm_sram_bank #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_bank (
            .clk   (clk),
            .en    (en),
            .we    (we),
            .idx   (idx),
            .be    (be),
            .wdata (wdata),
            .rdata (bank_rdata[b])
        );
    end

    tcm_rd_return u_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_fire   (core_valid && !core_write),
        .core_wide   (core_wide),
        .core_bank   (core_addr[3:2]),
        .dma_fire    (dma_fire && !dma_write),
        .dma_bank    (dma_addr[3:2]),
        .bank_rdata  (bank_rdata),
        .core_rvalid (core_rvalid),
        .core_rdata  (core_rdata),
        .dma_rvalid  (dma_rvalid),
        .dma_rdata   (dma_rdata)
    );
endmodule

// File: rtl/tcm_arb_chk.sv
// Protocol checks on the arbiter ports, attached to every instance by bind.
module tcm_arb_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_valid,
    input logic              core_write,
    input logic              core_rvalid,
    input logic              dma_valid,
    input logic              dma_ready,
    input logic              dma_write,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              dma_rvalid
);
    // R5
    dma_stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dma_ready) |-> core_valid);

    // R6
    dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_addr) && $stable(dma_write)));

    // R8
    core_rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rvalid |-> $past(core_valid && !core_write));

    // R8
    dma_rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rvalid |-> $past(dma_valid && dma_ready && !dma_write));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!core_rvalid && !dma_rvalid));
endmodule

bind tcm_bank_arbiter tcm_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_valid  (core_valid),
    .core_write  (core_write),
    .core_rvalid (core_rvalid),
    .dma_valid   (dma_valid),
    .dma_ready   (dma_ready),
    .dma_write   (dma_write),
    .dma_addr    (dma_addr),
    .dma_rvalid  (dma_rvalid)
);

// File: tb/tb_tcm_bank_arbiter.sv
module tb_tcm_bank_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int AW         = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          core_valid, core_ready, core_write, core_wide;
    logic [AW-1:0] core_addr;
    logic [7:0]    core_be;
    logic [63:0]   core_wdata;
    logic          core_rvalid;
    logic [63:0]   core_rdata;
    logic          dma_valid, dma_ready, dma_write;
    logic [AW-1:0] dma_addr;
    logic [3:0]    dma_be;
    logic [31:0]   dma_wdata;
    logic          dma_rvalid;
    logic [31:0]   dma_rdata;

    tcm_bank_arbiter #(.DEPTH_WORDS(DEPTH)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    logic [31:0] mem [int];
    logic        exp_crv = 1'b0, exp_drv = 1'b0;
    logic [63:0] exp_crd = '0;
    logic [31:0] exp_drd = '0;
    logic        exp_cwide = 1'b0;
    bit          stalled = 0;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void put(int w, logic [31:0] d, logic [3:0] be);
        logic [31:0] v = mem.exists(w) ? mem[w] : 32'h0;
        for (int i = 0; i < 4; i++) if (be[i]) v[8*i +: 8] = d[8*i +: 8];
        mem[w] = v;
    endfunction

    function automatic logic [31:0] get(int w);
        return mem.exists(w) ? mem[w] : 32'h0;
    endfunction

    task automatic idle();
        core_valid = 0; core_write = 0; core_wide = 0; core_addr = '0;
        core_be = '0; core_wdata = '0;
        dma_valid = 0; dma_write = 0; dma_addr = '0; dma_be = '0; dma_wdata = '0;
    endtask

    task automatic set_core(bit v, bit wr, bit wide, int a, logic [7:0] be, logic [63:0] d);
        core_valid = v; core_write = wr; core_wide = wide;
        core_addr = AW'(a); core_be = be; core_wdata = d;
    endtask

    task automatic set_dma(bit v, bit wr, int a, logic [3:0] be, logic [31:0] d);
        dma_valid = v; dma_write = wr; dma_addr = AW'(a); dma_be = be; dma_wdata = d;
    endtask

    // One cycle: inputs are already driven at the falling edge
    task automatic step();
        int  lo, cnt, db, w0;
        bit  clash, go;
        #1;
        lo  = core_wide ? ((int'(core_addr) >> 3) & 1) * 2 : (int'(core_addr) >> 2) & 3;
        cnt = core_wide ? 2 : 1;
        db  = (int'(dma_addr) >> 2) & 3;
        clash = core_valid && (db >= lo) && (db < lo + cnt);
        go    = dma_valid && !clash;
        check("R4", "core_ready", 64'(core_ready), 64'd1);
        check("R5", "dma_ready", 64'(dma_ready), 64'(!clash));
        stalled = dma_valid && clash;
        // reads see memory before this cycle's writes (never the same word)
        exp_crv = core_valid && !core_write;
        exp_cwide = core_wide;
        if (core_wide) begin
            w0 = (int'(core_addr) >> 3) * 2;
            exp_crd = {get(w0 + 1), get(w0)};
        end else begin
            exp_crd = {32'h0, get(int'(core_addr) >> 2)};
        end
        exp_drv = go && !dma_write;
        exp_drd = get(int'(dma_addr) >> 2);
        if (core_valid && core_write) begin
            if (core_wide) begin
                w0 = (int'(core_addr) >> 3) * 2;
                put(w0, core_wdata[31:0], core_be[3:0]);
                put(w0 + 1, core_wdata[63:32], core_be[7:4]);
            end else begin
                put(int'(core_addr) >> 2, core_wdata[31:0], core_be[3:0]);
            end
        end
        if (go && dma_write) put(int'(dma_addr) >> 2, dma_wdata, dma_be);
        @(posedge clk);
        #1;
        check("R8", "core_rvalid", 64'(core_rvalid), 64'(exp_crv));
        check("R8", "dma_rvalid", 64'(dma_rvalid), 64'(exp_drv));
        if (exp_crv) check(exp_cwide ? "R3" : "R2", "core_rdata", core_rdata, exp_crd);
        if (exp_drv) check("R1", "dma_rdata", 64'(dma_rdata), 64'(exp_drd));
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R9", "core_rvalid in reset", 64'(core_rvalid), 64'd0);
        check("R9", "dma_rvalid in reset", 64'(dma_rvalid), 64'd0);
        @(negedge clk);
        rst_n = 1;
        idle();
        step();
        step();

        // R1 fill every word through the DMA port
        for (int w = 0; w < DEPTH; w++) begin
            set_dma(1, 1, w * 4, 4'hF, 32'hA500_0000 + 32'(w * 32'h0101));
            step();
        end
        idle();

        // R7 R2 partial narrow write, then read back by core and DMA
        set_core(1, 1, 0, 'h14, 8'h05, 64'h11223344);
        step();
        set_core(1, 0, 0, 'h14, 8'h00, '0);
        step();
        idle();
        set_dma(1, 0, 'h14, 4'h0, '0);
        step();

        // R6 wide core write on banks 2,3 while DMA reads bank 1
        set_core(1, 1, 1, 'h28, 8'hFF, 64'hCAFE0001_BEEF0002);
        set_dma(1, 0, 'h04, 4'h0, '0);
        step();

        // R5 R6 wide read on banks 2,3 collides with DMA on bank 3; hold
        set_core(1, 0, 1, 'h28, 8'h00, '0);
        set_dma(1, 0, 'h2C, 4'h0, '0);
        step();
        check("R6", "stall seen", 64'(stalled), 64'd1);
        core_valid = 0;
        step();

        // R3 address bit 2 ignored on a wide access
        idle();
        set_core(1, 0, 1, 'h2C, 8'h00, '0);
        step();
        // R3 wide write with split byte enables
        set_core(1, 1, 1, 'h30, 8'h81, 64'h12345678_9ABCDEF0);
        step();
        set_core(1, 0, 1, 'h30, 8'h00, '0);
        step();

        // R6 narrow collision with a DMA write on bank 2, released later
        set_core(1, 0, 0, 'h08, 8'h00, '0);
        set_dma(1, 1, 'h18, 4'h6, 32'h55AA55AA);
        step();
        step();
        core_valid = 0;
        step();
        idle();
        set_dma(1, 0, 'h18, 4'h0, '0);
        step();
        idle();

        // Mixed random traffic, DMA obeys the hold rule
        for (int i = 0; i < 600; i++) begin
            set_core($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1,
                     $urandom_range(0, 1) == 1, $urandom_range(0, 255),
                     8'($urandom), {$urandom, $urandom});
            if (!stalled)
                set_dma($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1,
                        $urandom_range(0, 255), 4'($urandom), $urandom);
            step();
        end
        idle();
        step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule